// File: doc/BRIEF.md
# Synchronous Smart-Card Bit Sequencer

This block moves single bits between a host system and a synchronous memory card. It produces the card clock from a divider enable and moves data MSB-first on falling card-clock edges. Incoming bits are sampled on rising edges. A reloadable length counter frames each transfer. Slot 0 of a frame and the state after its last slot are frame boundaries. At a boundary in transmit mode, firmware owns the IO line through a software bit and a software direction bit. The card clock can be parked at a chosen level. Together, these let firmware build start and stop conditions between frames.

Firmware writes an 8-bit control byte and a length value. A length write reloads the counter. Transmit bytes come from a byte source with a not-empty flag. Received bits leave one at a time on a valid strobe. The pending interrupt marks the end of a frame. It stays set until firmware clears it through the control byte.

Top module: `sync_card_seq`

## Requirements
- R1: After reset, cardClk, ioOe, irq, underrun, txPop and rxValid are all 0.
- R2: With control bit 6 (park) clear, each cardTick pulse toggles cardClk. With bit 6 set, cardClk takes the value of control bit 5 (park level) on the next clock and ignores cardTick.
- R3: After a length write of L, irq rises on the (L+1)-th falling card-clock edge and not before. Slot 0 ends at the first falling edge. Slots 1..L end at the following falling edges.
- R4: irq stays set until a control write with bit 0 set. If the end of a frame and such a write fall in the same cycle, irq is set.
- R5: In slot 0, or after the frame has ended, with control bit 2 (transmit) and bit 7 (boundary override enable) set, ioOut equals control bit 4 and ioOe equals control bit 3.
- R6: At a boundary in transmit mode with control bit 7 clear, ioOe is 0.
- R7: In transmit mode, data slots drive the byte MSB-first with ioOe high. Each bit appears after the falling card edge that opens its slot. txPop pulses once per byte taken.
- R8: If txValid is low when a new byte is needed, underrun is set and ioOut keeps the last data bit driven. A length write clears underrun.
- R9: In receive mode (control bit 2 clear), ioOe is 0 in data slots. ioIn is sampled on each rising card edge in slots 1..L and appears on rxBit with a one-cycle rxValid.
- R10: With control bit 1 (acknowledge mode) set in transmit mode, the last slot is released (ioOe 0), and its bit is sampled onto the receive sink.
- R11: With control bit 1 set in receive mode, the last slot drives control bit 4 with ioOe 1 and is not sampled.
- R12: A length write at any time returns the frame to slot 0 and clears the ended state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cardTick | input | 1 | Divider enable; one card clock half period per pulse |
| ctlWe | input | 1 | Control byte write strobe |
| ctlWdata | input | 8 | Control byte; bit 0 clears irq and is not stored |
| lenWe | input | 1 | Length write; reloads the counter |
| lenWdata | input | LEN_W | Frame length in data slots |
| txData | input | BYTE_W | Head byte of the transmit source |
| txValid | input | 1 | Transmit source not empty |
| txPop | output | 1 | Head byte taken this cycle |
| rxValid | output | 1 | Received bit valid |
| rxBit | output | 1 | Received bit |
| cardClk | output | 1 | Card clock |
| ioOut | output | 1 | IO line output value |
| ioOe | output | 1 | IO line output enable |
| ioIn | input | 1 | IO line input value |
| irq | output | 1 | Frame-end interrupt pending |
| underrun | output | 1 | Transmit source ran empty |

## Verification
The end-of-frame interrupt set and the firmware clear through the control byte can fall in the same system cycle. The bench provokes this with a zero-length frame. It raises cardTick for the falling edge that closes slot 0 and, in that same cycle, writes the control byte with the clear bit set. The design is judged correct if irq reads 1 afterwards. A later clear on its own must then bring irq to 0.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int CTL_W      = 8;
  localparam int SYNC_EN_B  = 7;  // boundary override enable
  localparam int PARK_B     = 6;  // freeze card clock
  localparam int PARK_LVL_B = 5;  // level of parked clock
  localparam int SW_IO_B    = 4;  // software IO value
  localparam int SW_DIR_B   = 3;  // software IO output enable
  localparam int TX_MODE_B  = 2;  // 1 = transmit, 0 = receive
  localparam int ACK_MODE_B = 1;  // last slot is an acknowledge slot
  localparam int IRQ_CLR_B  = 0;  // write-one clear, not stored

  typedef struct packed {
    logic advance;   // open next TX data slot
    logic sample;    // capture IO into RX sink
    logic swOwn;     // software bit owns IO
    logic relIo;     // IO not driven
    logic ackDrive;  // host drives acknowledge from software bit
    logic restart;   // frame reload
  } seqStrb_t;
endpackage

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cardTick,
  input  logic             ctlWe,
  input  logic [CTL_W-1:0] ctlWdata,
  input  logic             lenWe,
  input  logic [LEN_W-1:0] lenWdata,
  output logic             cardClk,
  output logic             irq,
  output logic             swIoBit,
  output logic             swIoDir,
  output seqStrb_t         strb
);
  logic [CTL_W-1:1] ctlReg;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] cnt;
  logic             done;

  logic syncEn, park, parkLvl, txMode, ackMode;
  logic riseEv, fallEv, boundary, lastSlot, ackSlot, irqSet, irqClr, nextIsAck;

  assign syncEn  = ctlReg[SYNC_EN_B];
  assign park    = ctlReg[PARK_B];
  assign parkLvl = ctlReg[PARK_LVL_B];
  assign swIoBit = ctlReg[SW_IO_B];
  assign swIoDir = ctlReg[SW_DIR_B];
  assign txMode  = ctlReg[TX_MODE_B];
  assign ackMode = ctlReg[ACK_MODE_B];
  assign irqClr  = ctlWe && ctlWdata[IRQ_CLR_B];

  // Card clock edge events
  assign riseEv = cardTick && !park && !cardClk;
  assign fallEv = cardTick && !park && cardClk;

  // Frame position decode
  assign boundary  = (cnt == '0) || done;
  assign lastSlot  = !done && (cnt == lenReg) && (cnt != '0);
  assign ackSlot   = ackMode && lastSlot;
  assign nextIsAck = ackMode && ((cnt + LEN_W'(1)) == lenReg);
  assign irqSet    = fallEv && !done && (cnt == lenReg) && !lenWe;

  always_comb begin
    strb          = '0;
    strb.restart  = lenWe;
    strb.swOwn    = boundary && txMode && syncEn;
    strb.ackDrive = !txMode && ackSlot;
    strb.relIo    = !txMode || (boundary && !syncEn) || ackSlot;
    strb.sample   = riseEv && !lenWe && !done && (cnt != '0) &&
                    (txMode ? ackSlot : !ackSlot);
    strb.advance  = fallEv && !lenWe && !done && (cnt != lenReg) &&
                    txMode && !nextIsAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= '0;
    end else if (ctlWe) begin
      ctlReg <= ctlWdata[CTL_W-1:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cardClk <= 1'b0;
    end else if (park) begin
      cardClk <= parkLvl;
    end else if (cardTick) begin
      cardClk <= !cardClk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else if (lenWe) begin
      lenReg <= lenWdata;
      cnt    <= '0;
      done   <= 1'b0;
    end else if (fallEv && !done) begin
      if (cnt == lenReg) begin
        done <= 1'b1;
      end else begin
        cnt <= cnt + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (irqSet) begin
      irq <= 1'b1;
    end else if (irqClr) begin
      irq <= 1'b0;
    end
  end

  // R2
  clk_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    park |=> (cardClk == $past(parkLvl)));

  // R2
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!park && !cardTick) |=> $stable(cardClk));

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

  // R3
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> done);

  // R12
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    lenWe |=> ((cnt == '0) && !done));
endmodule

// File: rtl/scs_dpath.sv
module scs_dpath
  import scs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic              swIoBit,
  input  logic              swIoDir,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  input  logic              ioIn,
  output logic              txPop,
  output logic              rxValid,
  output logic              rxBit,
  output logic              ioOut,
  output logic              ioOe,
  output logic              underrun
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shReg;
  logic [IDX_W-1:0]  bitIdx;
  logic              outBit;
  logic              firstBit;

  assign firstBit = (bitIdx == '0);
  assign txPop    = strb.advance && firstBit && txValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitIdx   <= '0;
      outBit   <= 1'b0;
      underrun <= 1'b0;
    end else if (strb.restart) begin
      bitIdx   <= '0;
      underrun <= 1'b0;
    end else if (strb.advance) begin
      if (firstBit) begin
        if (txValid) begin
          outBit <= txData[BYTE_W-1];
          shReg  <= txData << 1;
          bitIdx <= IDX_W'(1);
        end else begin
          underrun <= 1'b1;
        end
      end else begin
        outBit <= shReg[BYTE_W-1];
        shReg  <= shReg << 1;
        bitIdx <= (bitIdx == LAST_IDX) ? '0 : bitIdx + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxBit   <= 1'b0;
    end else begin
      rxValid <= strb.sample;
      if (strb.sample) begin
        rxBit <= ioIn;
      end
    end
  end

  always_comb begin
    if (strb.swOwn) begin
      ioOut = swIoBit;
      ioOe  = swIoDir;
    end else if (strb.ackDrive) begin
      ioOut = swIoBit;
      ioOe  = 1'b1;
    end else if (strb.relIo) begin
      ioOut = outBit;
      ioOe  = 1'b0;
    end else begin
      ioOut = outBit;
      ioOe  = 1'b1;
    end
  end

  // R8
  underrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !strb.restart) |=> underrun);

  // R9
  rx_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !$past(ioOe));
endmodule

// File: rtl/sync_card_seq.sv
module sync_card_seq
  import scs_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cardTick,
  input  logic              ctlWe,
  input  logic [7:0]        ctlWdata,
  input  logic              lenWe,
  input  logic [LEN_W-1:0]  lenWdata,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  output logic              txPop,
  output logic              rxValid,
  output logic              rxBit,
  output logic              cardClk,
  output logic              ioOut,
  output logic              ioOe,
  input  logic              ioIn,
  output logic              irq,
  output logic              underrun
);
  seqStrb_t strb;
  logic     swIoBit;
  logic     swIoDir;

  scs_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cardTick (cardTick),
    .ctlWe    (ctlWe),
    .ctlWdata (ctlWdata),
    .lenWe    (lenWe),
    .lenWdata (lenWdata),
    .cardClk  (cardClk),
    .irq      (irq),
    .swIoBit  (swIoBit),
    .swIoDir  (swIoDir),
    .strb     (strb)
  );

  scs_dpath #(.BYTE_W(BYTE_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .swIoBit  (swIoBit),
    .swIoDir  (swIoDir),
    .txData   (txData),
    .txValid  (txValid),
    .ioIn     (ioIn),
    .txPop    (txPop),
    .rxValid  (rxValid),
    .rxBit    (rxBit),
    .ioOut    (ioOut),
    .ioOe     (ioOe),
    .underrun (underrun)
  );

  // R7
  tx_msb_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && !ctlWe && !lenWe) |=> (ioOe && (ioOut == $past(txData[BYTE_W-1]))));
endmodule

// File: tb/sync_card_seq_tb_top.sv
module sync_card_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W  = 4;
  localparam int BYTE_W = 8;

  localparam logic [7:0] C_SYNC = 8'h80;
  localparam logic [7:0] C_PARK = 8'h40;
  localparam logic [7:0] C_LVL  = 8'h20;
  localparam logic [7:0] C_IOB  = 8'h10;
  localparam logic [7:0] C_DIR  = 8'h08;
  localparam logic [7:0] C_TX   = 8'h04;
  localparam logic [7:0] C_ACK  = 8'h02;
  localparam logic [7:0] C_CLR  = 8'h01;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cardTick = 1'b0;
  logic ctlWe = 1'b0;
  logic [7:0] ctlWdata = '0;
  logic lenWe = 1'b0;
  logic [LEN_W-1:0] lenWdata = '0;
  logic [BYTE_W-1:0] txData = '0;
  logic txValid = 1'b0;
  logic ioIn = 1'b1;
  logic txPop, rxValid, rxBit, cardClk, ioOut, ioOe, irq, underrun;

  int checks = 0;
  int fails = 0;
  int popCount = 0;
  int rxCount = 0;
  logic [15:0] rxShift = '0;
  logic finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_card_seq #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) dut_i (
    .clk(clk), .rstN(rstN), .cardTick(cardTick), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
    .lenWe(lenWe), .lenWdata(lenWdata), .txData(txData), .txValid(txValid),
    .txPop(txPop), .rxValid(rxValid), .rxBit(rxBit), .cardClk(cardClk),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .irq(irq), .underrun(underrun)
  );

  always @(posedge clk) begin
    if (txPop) popCount <= popCount + 1;
    if (rxValid) begin
      rxCount <= rxCount + 1;
      rxShift <= {rxShift[14:0], rxBit};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) cardTick = 1'b1;
    @(negedge clk) cardTick = 1'b0;
  endtask

  task automatic wrCtl(input logic [7:0] v);
    @(negedge clk) begin ctlWe = 1'b1; ctlWdata = v; end
    @(negedge clk) ctlWe = 1'b0;
  endtask

  task automatic reload(input int len);
    @(negedge clk) begin lenWe = 1'b1; lenWdata = LEN_W'(len); end
    @(negedge clk) lenWe = 1'b0;
  endtask

  task automatic clearCounts();
    @(negedge clk) begin popCount = 0; rxCount = 0; rxShift = '0; end
  endtask

  // Park clock high, reload, software start bit low, release clock.
  task automatic startFrame(input logic [7:0] base, input int len);
    wrCtl(base | C_PARK | C_LVL | C_DIR | C_CLR);
    step();
    reload(len);
    wrCtl(base | C_DIR);
  endtask

  task automatic testReset();
    chk("R1 cardClk", cardClk, 0);
    chk("R1 ioOe", ioOe, 0);
    chk("R1 irq", irq, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 txPop", txPop, 0);
    chk("R1 rxValid", rxValid, 0);
  endtask

  task automatic testTxByte();
    logic [7:0] b = 8'hA5;
    txData = b; txValid = 1'b1;
    clearCounts();
    startFrame(C_SYNC | C_TX, 8);
    chk("R5 start bit value", ioOut, 0);
    chk("R5 start bit oe", ioOe, 1);
    chk("R2 parked high", cardClk, 1);
    for (int i = 7; i >= 0; i--) begin
      tick();
      chk("R7 tx bit", ioOut, b[i]);
      chk("R7 tx oe", ioOe, 1);
      tick();
    end
    chk("R3 no early irq", irq, 0);
    tick();
    chk("R3 irq at end", irq, 1);
    chk("R5 boundary after end", {ioOe, ioOut}, 2'b10);
    chk("R7 one pop", popCount, 1);
    wrCtl(C_SYNC | C_TX | C_DIR | C_CLR);
    chk("R4 clear", irq, 0);
  endtask

  task automatic testClockPark();
    wrCtl(C_PARK);
    step();
    chk("R2 parked low", cardClk, 0);
    tick(); tick();
    chk("R2 ticks ignored", cardClk, 0);
    wrCtl(8'h00);
    tick();
    chk("R2 toggle high", cardClk, 1);
    tick();
    chk("R2 toggle low", cardClk, 0);
  endtask

  task automatic testUnderrun();
    txValid = 1'b0;
    startFrame(C_SYNC | C_TX, 2);
    tick();
    chk("R8 underrun set", underrun, 1);
    chk("R8 io holds last bit", ioOut, 1);
    wrCtl(C_SYNC | C_TX | C_PARK | C_LVL | C_DIR);
    reload(2);
    chk("R8 reload clears underrun", underrun, 0);
    chk("R12 back to slot 0", {ioOe, ioOut}, 2'b10);
    txValid = 1'b1;
  endtask

  task automatic testSetClear();
    startFrame(C_SYNC | C_TX, 0);
    chk("R3 zero length no irq", irq, 0);
    @(negedge clk) begin cardTick = 1'b1; ctlWe = 1'b1; ctlWdata = C_SYNC | C_TX | C_DIR | C_CLR; end
    @(negedge clk) begin cardTick = 1'b0; ctlWe = 1'b0; end
    chk("R4 set wins over clear", irq, 1);
    step();
    chk("R4 pending holds", irq, 1);
    wrCtl(C_SYNC | C_TX | C_DIR | C_CLR);
    chk("R4 clear alone", irq, 0);
  endtask

  task automatic testRx();
    logic [3:0] pat = 4'b1011;
    clearCounts();
    startFrame(C_SYNC, 4);
    tick();
    chk("R9 rx oe", ioOe, 0);
    for (int i = 3; i >= 0; i--) begin
      ioIn = pat[i];
      tick();
      tick();
    end
    chk("R3 rx irq", irq, 1);
    chk("R9 rx count", rxCount, 4);
    chk("R9 rx bits", rxShift[3:0], pat);
    chk("R9 rx released", ioOe, 0);
  endtask

  task automatic testAckTx();
    logic [7:0] b = 8'h3C;
    txData = b; txValid = 1'b1; ioIn = 1'b1;
    clearCounts();
    startFrame(C_SYNC | C_TX | C_ACK, 9);
    tick();
    for (int i = 7; i >= 0; i--) begin
      chk("R7 ack-mode tx bit", ioOut, b[i]);
      tick();
      tick();
    end
    chk("R10 ack slot released", ioOe, 0);
    ioIn = 1'b0;
    tick();
    tick();
    ioIn = 1'b1;
    chk("R10 ack sampled count", rxCount, 1);
    chk("R10 ack bit", rxShift[0], 0);
    chk("R10 one pop", popCount, 1);
    chk("R3 ack-mode irq", irq, 1);
  endtask

  task automatic testAckRx();
    logic [7:0] pat = 8'b1100_1010;
    clearCounts();
    startFrame(C_SYNC | C_ACK, 9);
    tick();
    for (int i = 7; i >= 0; i--) begin
      ioIn = pat[i];
      tick();
      tick();
    end
    wrCtl(C_SYNC | C_ACK | C_IOB | C_DIR);
    chk("R11 host ack driven", {ioOe, ioOut}, 2'b11);
    ioIn = 1'b0;
    tick();
    tick();
    ioIn = 1'b1;
    chk("R11 ack not sampled", rxCount, 8);
    chk("R9 ack-mode rx bits", rxShift[7:0], pat);
  endtask

  task automatic testStopAndDisable();
    wrCtl(C_SYNC | C_TX | C_PARK | C_LVL | C_DIR | C_CLR);
    step();
    reload(3);
    chk("R5 stop low phase", {cardClk, ioOe, ioOut}, 3'b110);
    wrCtl(C_SYNC | C_TX | C_PARK | C_LVL | C_DIR | C_IOB);
    chk("R5 stop rising io", {cardClk, ioOe, ioOut}, 3'b111);
    wrCtl(C_TX | C_PARK | C_LVL | C_DIR | C_IOB);
    chk("R6 override disabled", ioOe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    testReset();
    testTxByte();
    testClockPark();
    testUnderrun();
    testSetClear();
    testRx();
    testAckTx();
    testAckRx();
    testStopAndDisable();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule